// File: doc/BRIEF.md
# Fixed-Priority Maskable Interrupt Controller

This block gathers twelve interrupt requests: a reset request, a power-down request, six external request pins and the completion pulses of the on-chip timer, the byte DMA engine and two serial ports. Every request enters a pending stage that suits its sensitivity. A fixed-edge, power-down or internal request sets a latch that holds until software acknowledges it. A fixed-level request is pending only while its pin is driven. Three pins can be set to either behaviour at run time. Pending requests then pass through a per-source enable bit and a global enable, and a fixed-priority encoder picks the winner.

The sequencer reads `irq_valid_o` and `irq_vec_o`. When it takes the interrupt it pulses `ack_i` for one cycle, and that pulse clears the pending latch of the request on display. Two serial-port slots can be taken over by external pins when those pins are wired as extra interrupt requests. External pins are asynchronous and active-low. The internal pulses are synchronous and active-high.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While `sys_reset_req_i` is high, the output shows index 0 (vector 0). Neither the enable bits nor the global enable affect it.
- R2: A falling edge on `pwrdn_req_n_i` latches power-down (index 1, vector 4). The enable bits and the global enable do not gate it, and it stays pending until acknowledged.
- R3: The lowest pending enabled index wins. The vector equals index*4. The index order is: reset 0, power-down 1, programmable pin A 2, level pin B 3, level pin C 4, serial port 0 transmit 5, serial port 0 receive 6, edge pin D 7, byte DMA 8, shared slot E 9, shared slot F 10, timer 11. When nothing is presented, `irq_valid_o` is 0 and `irq_vec_o` is 0.
- R4: For indices 2 to 11, `mask_i[i]`=1 enables index i. Bits 0 and 1 of `mask_i` have no effect. A masked latched request stays pending and is presented once it is enabled.
- R5: When `glb_en_i`=0, indices 2 to 11 are blocked.
- R6: Pins B (`ext_req_n_i[1]`) and C (`ext_req_n_i[2]`) are pending only while they are low. They are never latched, and `ack_i` has no effect on them.
- R7: Pin D (`ext_req_n_i[3]`) latches on a falling edge. `ack_i` clears it while vector 28 is presented. A pin held low does not set the latch again.
- R8: `edge_sel_i` bits 0, 1 and 2 select the sensitivity of pin A (`ext_req_n_i[0]`), pin E (`ext_req_n_i[4]`) and pin F (`ext_req_n_i[5]`): 1 selects falling-edge latched, 0 selects level. Selecting level mode discards a latched request.
- R9: The `int_pulse_i` bits are serial port 0 transmit (bit 0), serial port 0 receive (bit 1), byte DMA (bit 2), serial port 1 transmit (bit 3), serial port 1 receive (bit 4) and timer (bit 5). A one-cycle high pulse latches the request until it is acknowledged.
- R10: With `shared_irq_mode_i`=1, indices 9 and 10 come from pins E and F, and `int_pulse_i` bits 3 and 4 are ignored. With 0, the reverse holds.
- R11: `ack_i` clears only the latch of the index presented in that cycle. If a new event for the same source arrives in the same cycle, the latch stays set.
- R12: A pin change passes two synchronizer flops. A level request is presented after the second rising edge, and an edge request after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sys_reset_req_i | input | 1 | Reset request, level, active-high |
| pwrdn_req_n_i | input | 1 | Power-down request pin, active-low, asynchronous |
| ext_req_n_i | input | 6 | External request pins A..F, active-low, asynchronous |
| int_pulse_i | input | 6 | Internal completion pulses |
| edge_sel_i | input | 3 | Sensitivity select for pins A, E, F |
| shared_irq_mode_i | input | 1 | Route pins E/F to indices 9/10 |
| mask_i | input | 12 | Per-index enable |
| glb_en_i | input | 1 | Global enable for maskable indices |
| ack_i | input | 1 | Acknowledge of the presented request |
| irq_valid_o | output | 1 | A request is presented |
| irq_vec_o | output | 6 | Vector address (index*4) |

## Verification
The acknowledge and a fresh event for the latched source being acknowledged can fall on the same clock edge. The bench provokes this on the timer slot by driving `ack_i` and the timer pulse in the same cycle. It then checks that vector 44 is still presented, and that only a second, lone acknowledge clears it. A second collision is an acknowledge while a lower-priority latched request waits. In that case only the presented index is cleared, and the waiting index takes over on the next cycle.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int NUM_SRC  = 12;
    localparam int NUM_EXT  = 6;
    localparam int NUM_INT  = 6;
    localparam int NUM_PROG = 3;
    localparam int IDX_W    = $clog2(NUM_SRC);
    localparam int VEC_W    = IDX_W + 2;

    // priority indices (lower wins)
    localparam int IX_RESET   = 0;
    localparam int IX_PWRDN   = 1;
    localparam int IX_PROG_A  = 2;
    localparam int IX_LVL_B   = 3;
    localparam int IX_LVL_C   = 4;
    localparam int IX_SP0_TX  = 5;
    localparam int IX_SP0_RX  = 6;
    localparam int IX_EDGE_D  = 7;
    localparam int IX_BYTEDMA = 8;
    localparam int IX_SH_E    = 9;
    localparam int IX_SH_F    = 10;
    localparam int IX_TIMER   = 11;

    // external pin bits
    localparam int EB_PROG_A = 0;
    localparam int EB_LVL_B  = 1;
    localparam int EB_LVL_C  = 2;
    localparam int EB_EDGE_D = 3;
    localparam int EB_SH_E   = 4;
    localparam int EB_SH_F   = 5;

    // internal pulse bits
    localparam int IP_SP0_TX  = 0;
    localparam int IP_SP0_RX  = 1;
    localparam int IP_BYTEDMA = 2;
    localparam int IP_SP1_TX  = 3;
    localparam int IP_SP1_RX  = 4;
    localparam int IP_TIMER   = 5;

    typedef struct packed {
        logic [NUM_EXT-1:0] ext_prev;
        logic               pwd_prev;
        logic [NUM_SRC-1:0] latch;
    } ctrl_state_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int   W       = 7,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1 <= {W{RST_VAL}};
            st_q.s2 <= {W{RST_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N  = 12,
    parameter int IW = 4
) (
    input  logic [N-1:0]  cand_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        any_o = |cand_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sys_reset_req_i,
    input  logic                pwrdn_req_n_i,
    input  logic [NUM_EXT-1:0]  ext_req_n_i,
    input  logic [NUM_INT-1:0]  int_pulse_i,
    input  logic [NUM_PROG-1:0] edge_sel_i,
    input  logic                shared_irq_mode_i,
    input  logic [NUM_SRC-1:0]  mask_i,
    input  logic                glb_en_i,
    input  logic                ack_i,
    output logic                irq_valid_o,
    output logic [VEC_W-1:0]    irq_vec_o
);
    localparam int SYNC_W = NUM_EXT + 1;
    localparam int NMI_CNT = 2;

    ctrl_state_t st_d, st_q;

    logic [SYNC_W-1:0]  sync_out;
    logic [NUM_EXT-1:0] ext_s, ext_act, ext_fall;
    logic               pwd_s, pwd_fall;
    logic [NUM_SRC-1:0] lvl_req, set_v, latch_mode, clr_v, pending, en_v, cand;
    logic               any_valid;
    logic [IDX_W-1:0]   win_idx;
    logic               unused_mask_bits;

    irq_sync #(.W(SYNC_W), .RST_VAL(1'b1)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({pwrdn_req_n_i, ext_req_n_i}),
        .sync_o  (sync_out)
    );

    assign ext_s    = sync_out[NUM_EXT-1:0];
    assign pwd_s    = sync_out[NUM_EXT];
    assign ext_act  = ~ext_s;
    assign ext_fall = st_q.ext_prev & ~ext_s;
    assign pwd_fall = st_q.pwd_prev & ~pwd_s;

    // enable per index: the non-maskable ones bypass mask and global enable
    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_en
            if (g < NMI_CNT) begin : g_nmi
                assign en_v[g] = 1'b1;
            end else begin : g_mask
                assign en_v[g] = mask_i[g] & glb_en_i;
            end
        end
    endgenerate
    assign unused_mask_bits = ^mask_i[NMI_CNT-1:0];

    always_comb begin
        lvl_req    = '0;
        set_v      = '0;
        latch_mode = '0;

        lvl_req[IX_RESET]     = sys_reset_req_i;

        latch_mode[IX_PWRDN]  = 1'b1;
        set_v[IX_PWRDN]       = pwd_fall;

        latch_mode[IX_PROG_A] = edge_sel_i[0];
        lvl_req[IX_PROG_A]    = ext_act[EB_PROG_A];
        set_v[IX_PROG_A]      = ext_fall[EB_PROG_A];

        lvl_req[IX_LVL_B]     = ext_act[EB_LVL_B];
        lvl_req[IX_LVL_C]     = ext_act[EB_LVL_C];

        latch_mode[IX_SP0_TX] = 1'b1;
        set_v[IX_SP0_TX]      = int_pulse_i[IP_SP0_TX];
        latch_mode[IX_SP0_RX] = 1'b1;
        set_v[IX_SP0_RX]      = int_pulse_i[IP_SP0_RX];

        latch_mode[IX_EDGE_D] = 1'b1;
        set_v[IX_EDGE_D]      = ext_fall[EB_EDGE_D];

        latch_mode[IX_BYTEDMA] = 1'b1;
        set_v[IX_BYTEDMA]      = int_pulse_i[IP_BYTEDMA];

        if (shared_irq_mode_i) begin
            latch_mode[IX_SH_E] = edge_sel_i[1];
            lvl_req[IX_SH_E]    = ext_act[EB_SH_E];
            set_v[IX_SH_E]      = ext_fall[EB_SH_E];
            latch_mode[IX_SH_F] = edge_sel_i[2];
            lvl_req[IX_SH_F]    = ext_act[EB_SH_F];
            set_v[IX_SH_F]      = ext_fall[EB_SH_F];
        end else begin
            latch_mode[IX_SH_E] = 1'b1;
            set_v[IX_SH_E]      = int_pulse_i[IP_SP1_TX];
            latch_mode[IX_SH_F] = 1'b1;
            set_v[IX_SH_F]      = int_pulse_i[IP_SP1_RX];
        end

        latch_mode[IX_TIMER] = 1'b1;
        set_v[IX_TIMER]      = int_pulse_i[IP_TIMER];

        pending = (latch_mode & st_q.latch) | (~latch_mode & lvl_req);
        cand    = pending & en_v;

        clr_v = (ack_i && any_valid) ? (NUM_SRC'(1) << win_idx) : '0;

        st_d.latch    = ((st_q.latch & ~clr_v) | set_v) & latch_mode;
        st_d.ext_prev = ext_s;
        st_d.pwd_prev = pwd_s;
    end

    irq_prio_enc #(.N(NUM_SRC), .IW(IDX_W)) enc_i (
        .cand_i (cand),
        .any_o  (any_valid),
        .idx_o  (win_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ext_prev <= '1;
            st_q.pwd_prev <= 1'b1;
            st_q.latch    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_valid_o = any_valid;
    assign irq_vec_o   = any_valid ? {win_idx, 2'b00} : '0;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
    import irq_prio_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               sys_reset_req_i,
    input logic [NUM_SRC-1:0] mask_i,
    input logic               glb_en_i,
    input logic               irq_valid_o,
    input logic [VEC_W-1:0]   irq_vec_o
);
    a_r1_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req_i |-> (irq_valid_o && irq_vec_o == '0));

    a_r5_glb_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en_i && irq_valid_o) |-> (irq_vec_o <= VEC_W'(4)));

    a_r4_mask_honored: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid_o && irq_vec_o >= VEC_W'(8)) |-> mask_i[irq_vec_o[VEC_W-1:2]]);

    a_r3_vec_form: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> (irq_vec_o[1:0] == 2'b00 && irq_vec_o[VEC_W-1:2] < IDX_W'(NUM_SRC)));

    a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid_o |-> (irq_vec_o == '0));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .sys_reset_req_i (sys_reset_req_i),
    .mask_i          (mask_i),
    .glb_en_i        (glb_en_i),
    .irq_valid_o     (irq_valid_o),
    .irq_vec_o       (irq_vec_o)
);

// File: tb/irq_prio_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sys_reset_req_i = 1'b0;
    logic        pwrdn_req_n_i = 1'b1;
    logic [5:0]  ext_req_n_i = '1;
    logic [5:0]  int_pulse_i = '0;
    logic [2:0]  edge_sel_i = '0;
    logic        shared_irq_mode_i = 1'b0;
    logic [11:0] mask_i = '1;
    logic        glb_en_i = 1'b1;
    logic        ack_i = 1'b0;
    logic        irq_valid_o;
    logic [5:0]  irq_vec_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irq_prio_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .sys_reset_req_i(sys_reset_req_i),
        .pwrdn_req_n_i(pwrdn_req_n_i), .ext_req_n_i(ext_req_n_i),
        .int_pulse_i(int_pulse_i), .edge_sel_i(edge_sel_i),
        .shared_irq_mode_i(shared_irq_mode_i), .mask_i(mask_i),
        .glb_en_i(glb_en_i), .ack_i(ack_i),
        .irq_valid_o(irq_valid_o), .irq_vec_o(irq_vec_o)
    );

    function automatic int obs();
        return irq_valid_o ? int'(irq_vec_o) : -1;
    endfunction

    // expected vector from pending set, enables (R3, R4, R5)
    function automatic int exp_vec(logic [11:0] pend, logic [11:0] msk, logic glb);
        for (int i = 0; i < 12; i++)
            if (pend[i] && (i < 2 || (msk[i] && glb))) return i * 4;
        return -1;
    endfunction

    function automatic int pulse_to_idx(int b);
        case (b)
            0: return 5;  1: return 6;  2: return 8;
            3: return 9;  4: return 10; default: return 11;
        endcase
    endfunction

    task automatic chk(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sys_reset_req_i = 0; pwrdn_req_n_i = 1; ext_req_n_i = '1; int_pulse_i = '0;
        edge_sel_i = '0; shared_irq_mode_i = 0; mask_i = '1; glb_en_i = 1; ack_i = 0;
        cyc(2);
        rst_n = 1'b1;
        cyc(2);
    endtask

    task automatic pulse(int b);
        int_pulse_i[b] = 1'b1;
        cyc(1);
        int_pulse_i[b] = 1'b0;
    endtask

    task automatic ack();
        ack_i = 1'b1;
        cyc(1);
        ack_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [11:0] lat;
        logic [11:0] pend;
        int e;
        void'($urandom(32'h5EED_0042));
        do_reset();
        chk("R3 reset state idle", obs(), -1);

        // random phase: level pins A(level mode),B,C, reset req, internal pulses
        lat = '0;
        for (int it = 0; it < 300; it++) begin
            mask_i          = 12'($urandom);
            glb_en_i        = ($urandom % 4) != 0;
            ext_req_n_i[2:0] = 3'($urandom);
            sys_reset_req_i = ($urandom % 10) == 0;
            if ($urandom % 2) begin
                int b;
                b = $urandom % 6;
                int_pulse_i[b] = 1'b1;
                lat[pulse_to_idx(b)] = 1'b1;
            end
            cyc(1);
            int_pulse_i = '0;
            cyc(2);
            pend = lat;
            pend[0] = sys_reset_req_i;
            pend[2] = ~ext_req_n_i[0];
            pend[3] = ~ext_req_n_i[1];
            pend[4] = ~ext_req_n_i[2];
            e = exp_vec(pend, mask_i, glb_en_i);
            chk("R3/R4/R5/R9 random priority", obs(), e);
            if ($urandom % 3 == 0) begin
                ack();
                if (e >= 0 && lat[e/4]) lat[e/4] = 1'b0;
            end
        end

        // R12 latency for level pin B and edge pin D
        do_reset();
        ext_req_n_i[1] = 1'b0;
        cyc(1); chk("R12 level after one edge", obs(), -1);
        cyc(1); chk("R12 level after two edges", obs(), 12);
        ext_req_n_i[1] = 1'b1;
        cyc(3);
        ext_req_n_i[3] = 1'b0;
        cyc(2); chk("R12 edge after two edges", obs(), -1);
        cyc(1); chk("R12 edge after three edges", obs(), 28);

        // R7 edge pin D: held low, masked retention, ack, no retrigger
        ack(); cyc(1);
        chk("R7 ack clears edge latch", obs(), -1);
        cyc(4);
        chk("R7 held low no retrigger", obs(), -1);
        ext_req_n_i[3] = 1'b1; cyc(3);
        mask_i[7] = 1'b0;
        ext_req_n_i[3] = 1'b0; cyc(4); ext_req_n_i[3] = 1'b1; cyc(3);
        chk("R4 masked edge not shown", obs(), -1);
        mask_i[7] = 1'b1; cyc(1);
        chk("R4 R7 masked edge kept pending", obs(), 28);

        // R6 level pins ignore ack, R5 global enable
        do_reset();
        ext_req_n_i[2] = 1'b0; cyc(3);
        chk("R6 level pin C", obs(), 16);
        ack();
        chk("R6 ack no effect on level", obs(), 16);
        glb_en_i = 1'b0; cyc(1);
        chk("R5 global enable blocks", obs(), -1);
        glb_en_i = 1'b1;
        ext_req_n_i[2] = 1'b1; cyc(3);
        chk("R6 level released", obs(), -1);

        // R2 power-down, R1 reset precedence
        do_reset();
        mask_i = '0; glb_en_i = 1'b0;
        ext_req_n_i[1] = 1'b0;
        pwrdn_req_n_i = 1'b0; cyc(4); pwrdn_req_n_i = 1'b1; cyc(3);
        chk("R2 power-down unmaskable", obs(), 4);
        sys_reset_req_i = 1'b1; cyc(1);
        chk("R1 reset above power-down", obs(), 0);
        ack();
        chk("R1 reset ack ignored", obs(), 0);
        sys_reset_req_i = 1'b0; cyc(1);
        chk("R2 power-down still latched", obs(), 4);
        ack();
        chk("R2 ack clears power-down", obs(), -1);
        glb_en_i = 1'b1; mask_i = '1; cyc(1);
        chk("R3 level B shows after enable", obs(), 12);

        // R8 programmable pin A
        do_reset();
        edge_sel_i[0] = 1'b1;
        ext_req_n_i[0] = 1'b0; cyc(3); ext_req_n_i[0] = 1'b1; cyc(3);
        chk("R8 edge mode latched", obs(), 8);
        edge_sel_i[0] = 1'b0; cyc(1);
        chk("R8 level mode drops latch", obs(), -1);
        edge_sel_i[0] = 1'b1; cyc(1);
        chk("R8 latch discarded", obs(), -1);
        edge_sel_i[0] = 1'b0;
        ext_req_n_i[0] = 1'b0; cyc(3);
        chk("R8 level mode low", obs(), 8);
        ext_req_n_i[0] = 1'b1; cyc(3);
        chk("R8 level mode high", obs(), -1);

        // R10 shared slots
        do_reset();
        shared_irq_mode_i = 1'b1;
        pulse(3); cyc(1);
        chk("R10 pulse ignored in pin mode", obs(), -1);
        ext_req_n_i[4] = 1'b0; cyc(3);
        chk("R10 pin E level", obs(), 36);
        ext_req_n_i[4] = 1'b1;
        edge_sel_i[2] = 1'b1;
        ext_req_n_i[5] = 1'b0; cyc(3); ext_req_n_i[5] = 1'b1; cyc(3);
        chk("R10 R8 pin F edge", obs(), 40);
        ack();
        shared_irq_mode_i = 1'b0;
        ext_req_n_i[4] = 1'b0; cyc(3);
        chk("R10 pin ignored in port mode", obs(), -1);
        ext_req_n_i[4] = 1'b1;
        pulse(4); cyc(1);
        chk("R10 R9 port receive pulse", obs(), 40);

        // R11 ack selectivity and same-cycle set
        do_reset();
        pulse(5); pulse(0);
        chk("R9 two latched", obs(), 20);
        ack();
        chk("R11 ack clears only presented", obs(), 44);
        ack_i = 1'b1; int_pulse_i[5] = 1'b1;
        cyc(1);
        ack_i = 1'b0; int_pulse_i[5] = 1'b0;
        chk("R11 new event wins over ack", obs(), 44);
        ack();
        chk("R11 lone ack clears", obs(), -1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule